// File: doc/BRIEF.md
# AUX Reply Status Decoder

This block sits behind a display auxiliary-channel receiver and turns a finished reception into a verdict the requesting logic can act on. When the requester issues a one-cycle `start`, the block polls the receiver's done flag at fixed intervals. At each poll it looks at the hot-plug loss flag, the receive error flags and the received byte count. If nothing rules the reply out, it reads the first received byte, which carries the reply command in its upper nibble.

On an acknowledged reply the block copies the data bytes that follow the status byte into the requester's buffer, one byte per cycle. It then pulses `res_valid` together with a result code, a reply status and the number of bytes copied. If done never shows up within the configured number of polls, the outcome is a timeout. The physical receiver and any retry policy live elsewhere.

Top module: `aux_reply_classifier`

## Requirements
- R1: After reset `res_valid` and `out_we` are low and `res_code`, `reply_st` and `data_cnt` are zero.
- R2: If `hpd_lost` is high at a poll, the result is disconnect (`res_code`=3, `reply_st`=5, `data_cnt`=0). This holds whatever done, the flags and the count show.
- R3: At a poll with done high, `rx_flags` bit 0 (receive timeout) or bit 1 (timeout state) gives `res_code`=1. This takes precedence over the framing flags.
- R4: At a poll with done high and no timeout flag, any of `rx_flags` bits 2 to 5 (bad stop, no receive detected, bad high symbol, bad low symbol) gives `res_code`=2. Bit 6 (minimum-count violation) has no effect on the outcome.
- R5: A clean reception with `rx_count`=0 gives `res_code`=2.
- R6: The inputs are sampled only at polls, which fall every POLL_STEP cycles after the cycle that accepted `start`. A verdict reached at a poll is visible through `res_valid`, a pulse exactly one cycle long, in the cycle after that poll's clock edge.
- R7: If no poll sees done after TIMEOUT_CYC/POLL_STEP polls, the result is `res_code`=1.
- R8: The reply command is bits 7:4 of receive-buffer byte 0; bits 3:0 are ignored. The command maps to `reply_st` as follows: 0 to ACK (0), 1 to NACK (1), 2 to DEFER (2), 4 to I2C NACK (3), 8 to I2C DEFER (4). Any other command gives 5 (invalid) with `res_code`=2.
- R9: On ACK, buffer bytes 1 to `rx_count`-1 are written to `out_addr` 0 upward with `out_we` high, one per cycle and with no gaps. The result then reports `res_code`=0 and `data_cnt`=`rx_count`-1.
- R10: On ACK with `rx_count`-1 greater than `cap_bytes`, no byte is written and the result is `res_code`=2, `reply_st`=0, `data_cnt`=0. A count equal to the capacity is accepted.
- R11: A NACK or DEFER reply of either kind writes no data and reports `res_code`=0 with `data_cnt`=0.
- R12: A `start` pulse while a reception is being processed is ignored and does not shift the poll schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin watching a reception (one-cycle pulse) |
| rx_done | input | 1 | Receiver reports the reception finished |
| rx_count | input | CNT_W | Received byte count, status byte included |
| rx_flags | input | 7 | Receive error flags, bit positions as in R3 and R4 |
| hpd_lost | input | 1 | Hot-plug disconnect seen |
| cap_bytes | input | CNT_W | Capacity of the requester's data buffer in bytes |
| buf_rd_addr | output | IDX_W | Receive-buffer read index |
| buf_rd_data | input | 8 | Receive-buffer byte at `buf_rd_addr`, same cycle |
| out_we | output | 1 | Write strobe into the requester's buffer |
| out_addr | output | IDX_W | Requester-buffer write index |
| out_data | output | 8 | Requester-buffer write byte |
| res_valid | output | 1 | One-cycle verdict pulse |
| res_code | output | 2 | 0 success, 1 timeout, 2 invalid reply, 3 disconnect |
| reply_st | output | 3 | Reply status as encoded in R8 |
| data_cnt | output | CNT_W | Number of data bytes copied |

## Verification
The bench builds the block with BUF_DEPTH=20 and POLL_STEP=10, and lowers TIMEOUT_CYC to 60, so a missing done exhausts its six polls within a few dozen cycles. The last-poll timeout path and the late-done case, where done is caught on the second poll, are therefore both reached cheaply. A buffer depth of 20 leaves room for a full 16-byte payload plus the status byte, and it lets the capacity check be driven on both sides of its boundary.

// File: rtl/aux_rc_pkg.sv
package aux_rc_pkg;

    localparam int FLAG_W = 7;

    // rx_flags bit positions
    localparam logic [FLAG_W-1:0] TMO_MASK   = 7'b000_0011;
    localparam logic [FLAG_W-1:0] FRAME_MASK = 7'b011_1100;

    typedef enum logic [1:0] {
        RES_OK   = 2'd0,
        RES_TMO  = 2'd1,
        RES_INV  = 2'd2,
        RES_DISC = 2'd3
    } result_e;

    typedef enum logic [2:0] {
        RP_ACK       = 3'd0,
        RP_NACK      = 3'd1,
        RP_DEFER     = 3'd2,
        RP_I2C_NACK  = 3'd3,
        RP_I2C_DEFER = 3'd4,
        RP_INVALID   = 3'd5
    } reply_e;

    typedef enum logic [1:0] {
        SCR_GO,
        SCR_TMO,
        SCR_BAD
    } screen_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_STAT,
        ST_COPY
    } fsm_e;

    typedef struct packed {
        result_e res;
        reply_e  rp;
    } verdict_t;

    function automatic reply_e decode_cmd(input logic [3:0] cmd);
        case (cmd)
            4'd0:    return RP_ACK;
            4'd1:    return RP_NACK;
            4'd2:    return RP_DEFER;
            4'd4:    return RP_I2C_NACK;
            4'd8:    return RP_I2C_DEFER;
            default: return RP_INVALID;
        endcase
    endfunction

endpackage

// File: rtl/aux_poll_timer.sv
module aux_poll_timer #(
    parameter int POLL_STEP   = 10,
    parameter int TIMEOUT_CYC = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic run,
    output logic poll,
    output logic last
);
    localparam int MAX_POLLS = (TIMEOUT_CYC / POLL_STEP) > 0 ? (TIMEOUT_CYC / POLL_STEP) : 1;
    localparam int PS_W      = POLL_STEP > 1 ? $clog2(POLL_STEP) : 1;
    localparam int PC_W      = $clog2(MAX_POLLS + 1);

    logic [PS_W-1:0] pre_q;
    logic [PC_W-1:0] polls_q;
    logic            wrap;

    assign wrap = (pre_q == PS_W'(POLL_STEP - 1));
    assign poll = run && wrap;
    assign last = poll && (polls_q == PC_W'(MAX_POLLS - 1));

    always_ff @(posedge clk) begin
        if (rst || arm) begin
            pre_q   <= '0;
            polls_q <= '0;
        end else if (run) begin
            if (wrap) begin
                pre_q   <= '0;
                polls_q <= polls_q + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/aux_rx_screen.sv
module aux_rx_screen
    import aux_rc_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic [FLAG_W-1:0] rx_flags,
    input  logic [CNT_W-1:0]  rx_count,
    output screen_e           verdict
);
    logic tmo_hit;
    logic frame_hit;
    logic unused_flags;

    assign tmo_hit      = |(rx_flags & TMO_MASK);
    assign frame_hit    = |(rx_flags & FRAME_MASK);
    assign unused_flags = ^(rx_flags & ~(TMO_MASK | FRAME_MASK));

    always_comb begin
        if (tmo_hit)
            verdict = SCR_TMO;
        else if (frame_hit || (rx_count == '0))
            verdict = SCR_BAD;
        else
            verdict = SCR_GO;
    end
endmodule

// File: rtl/aux_reply_classifier.sv
module aux_reply_classifier
    import aux_rc_pkg::*;
#(
    parameter int BUF_DEPTH   = 20,
    parameter int POLL_STEP   = 10,
    parameter int TIMEOUT_CYC = 1000,
    localparam int IDX_W      = $clog2(BUF_DEPTH),
    localparam int CNT_W      = $clog2(BUF_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              rx_done,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [FLAG_W-1:0] rx_flags,
    input  logic              hpd_lost,
    input  logic [CNT_W-1:0]  cap_bytes,
    output logic [IDX_W-1:0]  buf_rd_addr,
    input  logic [7:0]        buf_rd_data,
    output logic              out_we,
    output logic [IDX_W-1:0]  out_addr,
    output logic [7:0]        out_data,
    output logic              res_valid,
    output logic [1:0]        res_code,
    output logic [2:0]        reply_st,
    output logic [CNT_W-1:0]  data_cnt
);
    fsm_e             st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [CNT_W-1:0] ndata;
    logic             poll, last;
    screen_e          scr;
    reply_e           cmd_rp;

    logic             fin;
    verdict_t         fin_v;
    logic [CNT_W-1:0] fin_cnt;

    aux_poll_timer #(
        .POLL_STEP  (POLL_STEP),
        .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_timer (
        .clk (clk),
        .rst (rst),
        .arm (st_q == ST_IDLE && start),
        .run (st_q == ST_WAIT),
        .poll(poll),
        .last(last)
    );

    aux_rx_screen #(
        .CNT_W(CNT_W)
    ) u_screen (
        .rx_flags(rx_flags),
        .rx_count(rx_count),
        .verdict (scr)
    );

    assign ndata       = cnt_q - 1'b1;
    assign cmd_rp      = decode_cmd(buf_rd_data[7:4]);
    assign buf_rd_addr = (st_q == ST_COPY) ? idx_q : '0;
    assign out_we      = (st_q == ST_COPY);
    assign out_addr    = idx_q - 1'b1;
    assign out_data    = buf_rd_data;

    always_comb begin
        st_d    = st_q;
        cnt_d   = cnt_q;
        idx_d   = idx_q;
        fin     = 1'b0;
        fin_v   = '{res: RES_OK, rp: RP_INVALID};
        fin_cnt = '0;
        case (st_q)
            ST_IDLE: begin
                if (start) st_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (poll) begin
                    if (hpd_lost) begin
                        fin   = 1'b1;
                        fin_v = '{res: RES_DISC, rp: RP_INVALID};
                    end else if (rx_done) begin
                        if (scr == SCR_TMO) begin
                            fin   = 1'b1;
                            fin_v = '{res: RES_TMO, rp: RP_INVALID};
                        end else if (scr == SCR_BAD) begin
                            fin   = 1'b1;
                            fin_v = '{res: RES_INV, rp: RP_INVALID};
                        end else begin
                            st_d  = ST_STAT;
                            cnt_d = rx_count;
                        end
                    end else if (last) begin
                        fin   = 1'b1;
                        fin_v = '{res: RES_TMO, rp: RP_INVALID};
                    end
                end
            end
            ST_STAT: begin
                if (cmd_rp == RP_ACK) begin
                    if (ndata > cap_bytes) begin
                        fin   = 1'b1;
                        fin_v = '{res: RES_INV, rp: RP_ACK};
                    end else if (ndata == '0) begin
                        fin   = 1'b1;
                        fin_v = '{res: RES_OK, rp: RP_ACK};
                    end else begin
                        st_d  = ST_COPY;
                        idx_d = IDX_W'(1);
                    end
                end else begin
                    fin   = 1'b1;
                    fin_v = '{res: (cmd_rp == RP_INVALID) ? RES_INV : RES_OK, rp: cmd_rp};
                end
            end
            ST_COPY: begin
                if (CNT_W'(idx_q) == ndata) begin
                    fin     = 1'b1;
                    fin_v   = '{res: RES_OK, rp: RP_ACK};
                    fin_cnt = ndata;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            default: st_d = ST_IDLE;
        endcase
        if (fin) st_d = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            cnt_q     <= '0;
            idx_q     <= '0;
            res_valid <= 1'b0;
            res_code  <= '0;
            reply_st  <= '0;
            data_cnt  <= '0;
        end else begin
            st_q      <= st_d;
            cnt_q     <= cnt_d;
            idx_q     <= idx_d;
            res_valid <= fin;
            if (fin) begin
                res_code <= fin_v.res;
                reply_st <= fin_v.rp;
                data_cnt <= fin_cnt;
            end
        end
    end
endmodule

// File: rtl/aux_reply_classifier_chk.sv
module aux_reply_classifier_chk #(
    parameter int BUF_DEPTH = 20,
    localparam int IDX_W    = $clog2(BUF_DEPTH),
    localparam int CNT_W    = $clog2(BUF_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             res_valid,
    input logic [1:0]       res_code,
    input logic [2:0]       reply_st,
    input logic [CNT_W-1:0] data_cnt,
    input logic             out_we,
    input logic [IDX_W-1:0] out_addr
);
    // R6: the verdict is a single-cycle pulse
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    // R9: copying starts at index zero
    a_r9_first_addr: assert property (@(posedge clk) disable iff (rst)
        $rose(out_we) |-> out_addr == '0);

    // R9: consecutive writes advance by one
    a_r9_contiguous: assert property (@(posedge clk) disable iff (rst)
        out_we |=> (!out_we || out_addr == $past(out_addr) + 1'b1));

    // R9: the reported count matches the writes just made
    a_r9_count_match: assert property (@(posedge clk) disable iff (rst)
        $fell(out_we) |-> (res_valid && res_code == 2'd0 && data_cnt == CNT_W'($past(out_addr)) + 1'b1));

    // R2: disconnect carries no reply and no data
    a_r2_disc_clean: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_code == 2'd3) |-> (reply_st == 3'd5 && data_cnt == '0));

    // R10: any failing result reports no data
    a_r10_fail_no_data: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_code != 2'd0) |-> data_cnt == '0);

    // R11: non-ACK replies copy nothing
    a_r11_nack_no_data: assert property (@(posedge clk) disable iff (rst)
        (res_valid && reply_st != 3'd0) |-> data_cnt == '0);
endmodule

bind aux_reply_classifier aux_reply_classifier_chk #(
    .BUF_DEPTH(BUF_DEPTH)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .res_valid(res_valid),
    .res_code (res_code),
    .reply_st (reply_st),
    .data_cnt (data_cnt),
    .out_we   (out_we),
    .out_addr (out_addr)
);

// File: tb/aux_reply_classifier_tb.sv
`timescale 1ns/1ps
module aux_reply_classifier_tb;
    localparam int BUF_DEPTH   = 20;
    localparam int POLL_STEP   = 10;
    localparam int TIMEOUT_CYC = 60;
    localparam int NPOLL       = TIMEOUT_CYC / POLL_STEP;
    localparam int IDX_W       = $clog2(BUF_DEPTH);
    localparam int CNT_W       = $clog2(BUF_DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic             rx_done = 1'b0;
    logic [CNT_W-1:0] rx_count = '0;
    logic [6:0]       rx_flags = '0;
    logic             hpd_lost = 1'b0;
    logic [CNT_W-1:0] cap_bytes = CNT_W'(16);
    logic [IDX_W-1:0] buf_rd_addr;
    logic [7:0]       buf_rd_data;
    logic             out_we;
    logic [IDX_W-1:0] out_addr;
    logic [7:0]       out_data;
    logic             res_valid;
    logic [1:0]       res_code;
    logic [2:0]       reply_st;
    logic [CNT_W-1:0] data_cnt;

    logic [7:0] rxmem  [BUF_DEPTH];
    logic [7:0] capmem [BUF_DEPTH];

    always #2.5 clk = ~clk;

    assign buf_rd_data = rxmem[buf_rd_addr];

    aux_reply_classifier #(
        .BUF_DEPTH  (BUF_DEPTH),
        .POLL_STEP  (POLL_STEP),
        .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_dut (
        .clk(clk), .rst(rst), .start(start), .rx_done(rx_done),
        .rx_count(rx_count), .rx_flags(rx_flags), .hpd_lost(hpd_lost),
        .cap_bytes(cap_bytes), .buf_rd_addr(buf_rd_addr), .buf_rd_data(buf_rd_data),
        .out_we(out_we), .out_addr(out_addr), .out_data(out_data),
        .res_valid(res_valid), .res_code(res_code), .reply_st(reply_st),
        .data_cnt(data_cnt)
    );

    int    checks = 0;
    int    fails  = 0;
    string cur_tag = "R1";

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int ph = 0, wc = 0, np = 0, mcnt = 0, midx = 0;
    int m_code = 0, m_st = 0, m_dcnt = 0;
    bit m_valid = 0;

    task automatic mfin(input int c, input int s, input int n);
        m_valid = 1; m_code = c; m_st = s; m_dcnt = n; ph = 0;
    endtask

    always @(posedge clk) begin
        int cmd;
        m_valid = 0;
        if (rst) begin
            ph = 0; m_code = 0; m_st = 0; m_dcnt = 0;
        end else begin
            case (ph)
                0: if (start) begin ph = 1; wc = 0; np = 0; end
                1: begin
                    wc++;
                    if (wc == POLL_STEP) begin
                        wc = 0; np++;
                        if (hpd_lost) mfin(3, 5, 0);
                        else if (rx_done && (rx_flags & 7'h03) != 0) mfin(1, 5, 0);
                        else if (rx_done && (rx_flags & 7'h3c) != 0) mfin(2, 5, 0);
                        else if (rx_done && rx_count == 0) mfin(2, 5, 0);
                        else if (rx_done) begin ph = 2; mcnt = int'(rx_count); end
                        else if (np == NPOLL) mfin(1, 5, 0);
                    end
                end
                2: begin
                    cmd = int'(rxmem[0]) >> 4;
                    case (cmd)
                        0: begin
                            if (mcnt - 1 > int'(cap_bytes)) mfin(2, 0, 0);
                            else if (mcnt == 1) mfin(0, 0, 0);
                            else begin ph = 3; midx = 1; end
                        end
                        1: mfin(0, 1, 0);
                        2: mfin(0, 2, 0);
                        4: mfin(0, 3, 0);
                        8: mfin(0, 4, 0);
                        default: mfin(2, 5, 0);
                    endcase
                end
                3: if (midx == mcnt - 1) mfin(0, 0, mcnt - 1); else midx++;
                default: ph = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk({cur_tag, " res_valid"}, int'(res_valid), int'(m_valid));
            chk({cur_tag, " out_we"}, int'(out_we), int'(ph == 3));
            if (m_valid) begin
                chk({cur_tag, " res_code"}, int'(res_code), m_code);
                chk({cur_tag, " reply_st"}, int'(reply_st), m_st);
                chk({cur_tag, " data_cnt"}, int'(data_cnt), m_dcnt);
            end
            if (ph == 3) begin
                chk({cur_tag, " out_addr"}, int'(out_addr), midx - 1);
                chk({cur_tag, " out_data"}, int'(out_data), int'(rxmem[midx]));
            end
            if (out_we) capmem[out_addr] = out_data;
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            fails++;
            $display("FAIL watchdog: got %0d expected below %0d cycles", cyc, 50000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic setup(input bit d, input int cnt, input int flags, input bit hpd, input int cap);
        rx_done   = d;
        rx_count  = CNT_W'(cnt);
        rx_flags  = 7'(flags);
        hpd_lost  = hpd;
        cap_bytes = CNT_W'(cap);
    endtask

    // late: negedge index at which done rises (0 = never); restart: pulse start again mid-wait
    task automatic run(input string tag, input int late, input bit restart, output int lat);
        cur_tag = tag;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        lat = 0;
        while (!res_valid && lat < 200) begin
            @(negedge clk);
            lat++;
            if (late != 0 && lat == late) rx_done = 1'b1;
            if (restart && lat == 3) start = 1'b1;
            if (restart && lat == 4) start = 1'b0;
        end
    endtask

    task automatic expect_res(input string tag, input int lat, input int lat_exp,
                              input int c, input int s, input int n);
        chk({tag, " latency"}, lat, lat_exp);
        chk({tag, " code"}, int'(res_code), c);
        chk({tag, " status"}, int'(reply_st), s);
        chk({tag, " count"}, int'(data_cnt), n);
    endtask

    task automatic idle_gap();
        @(negedge clk);
        setup(0, 0, 0, 0, 16);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int lat;
        for (int i = 0; i < BUF_DEPTH; i++) begin rxmem[i] = 8'h00; capmem[i] = 8'h00; end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 res_valid", int'(res_valid), 0);
        chk("R1 out_we", int'(out_we), 0);
        chk("R1 res_code", int'(res_code), 0);
        chk("R1 data_cnt", int'(data_cnt), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R9: ACK with four data bytes, low nibble of status byte ignored
        rxmem[0] = 8'h05; rxmem[1] = 8'hA1; rxmem[2] = 8'hB2; rxmem[3] = 8'hC3; rxmem[4] = 8'hD4;
        setup(1, 5, 0, 0, 16);
        run("R9", 0, 0, lat);
        expect_res("R9", lat, 15, 0, 0, 4);
        chk("R9 byte0", int'(capmem[0]), 'hA1);
        chk("R9 byte3", int'(capmem[3]), 'hD4);
        idle_gap();

        // R11: NACK and DEFER copy nothing
        rxmem[0] = 8'h10; setup(1, 3, 0, 0, 16);
        run("R11", 0, 0, lat); expect_res("R11 nack", lat, 11, 0, 1, 0); idle_gap();
        rxmem[0] = 8'h20; setup(1, 3, 0, 0, 16);
        run("R11", 0, 0, lat); expect_res("R11 defer", lat, 11, 0, 2, 0); idle_gap();

        // R8: remaining command values
        rxmem[0] = 8'h4F; setup(1, 2, 0, 0, 16);
        run("R8", 0, 0, lat); expect_res("R8 i2c nack", lat, 11, 0, 3, 0); idle_gap();
        rxmem[0] = 8'h80; setup(1, 2, 0, 0, 16);
        run("R8", 0, 0, lat); expect_res("R8 i2c defer", lat, 11, 0, 4, 0); idle_gap();
        rxmem[0] = 8'h30; setup(1, 2, 0, 0, 16);
        run("R8", 0, 0, lat); expect_res("R8 cmd3", lat, 11, 2, 5, 0); idle_gap();
        rxmem[0] = 8'hF0; setup(1, 2, 0, 0, 16);
        run("R8", 0, 0, lat); expect_res("R8 cmdF", lat, 11, 2, 5, 0); idle_gap();

        // R2: disconnect wins over everything
        rxmem[0] = 8'h00; setup(1, 3, 7'h01, 1, 16);
        run("R2", 0, 0, lat); expect_res("R2", lat, 10, 3, 5, 0); idle_gap();
        setup(0, 0, 0, 1, 16);
        run("R2", 0, 0, lat); expect_res("R2 no done", lat, 10, 3, 5, 0); idle_gap();

        // R3: timeout flags, and their precedence over framing flags
        setup(1, 3, 7'h01, 0, 16);
        run("R3", 0, 0, lat); expect_res("R3 bit0", lat, 10, 1, 5, 0); idle_gap();
        setup(1, 3, 7'h02, 0, 16);
        run("R3", 0, 0, lat); expect_res("R3 bit1", lat, 10, 1, 5, 0); idle_gap();
        setup(1, 3, 7'h06, 0, 16);
        run("R3", 0, 0, lat); expect_res("R3 prio", lat, 10, 1, 5, 0); idle_gap();

        // R4: each framing flag, and the ignored minimum-count flag
        for (int b = 2; b < 6; b++) begin
            setup(1, 3, 1 << b, 0, 16);
            run("R4", 0, 0, lat); expect_res("R4 frame", lat, 10, 2, 5, 0); idle_gap();
        end
        rxmem[0] = 8'h00; setup(1, 1, 7'h40, 0, 16);
        run("R4", 0, 0, lat); expect_res("R4 min viol", lat, 11, 0, 0, 0); idle_gap();

        // R5: zero byte count
        setup(1, 0, 0, 0, 16);
        run("R5", 0, 0, lat); expect_res("R5", lat, 10, 2, 5, 0); idle_gap();

        // R7: done never arrives
        setup(0, 3, 0, 0, 16);
        run("R7", 0, 0, lat); expect_res("R7", lat, POLL_STEP * NPOLL, 1, 5, 0); idle_gap();

        // R6: done raised between polls is seen at the next poll only
        rxmem[0] = 8'h10; setup(0, 2, 0, 0, 16);
        run("R6", 15, 0, lat); expect_res("R6 late", lat, 21, 0, 1, 0); idle_gap();
        setup(0, 2, 7'h08, 0, 16);
        run("R6", 9, 0, lat); expect_res("R6 edge", lat, 10, 2, 5, 0); idle_gap();

        // R10: capacity boundary
        rxmem[0] = 8'h00; rxmem[1] = 8'h11; rxmem[2] = 8'h22; rxmem[3] = 8'h33; rxmem[4] = 8'h44;
        capmem[0] = 8'h00;
        setup(1, 5, 0, 0, 2);
        run("R10", 0, 0, lat); expect_res("R10 over", lat, 11, 2, 0, 0);
        chk("R10 untouched", int'(capmem[0]), 0);
        idle_gap();
        setup(1, 5, 0, 0, 4);
        run("R10", 0, 0, lat); expect_res("R10 equal", lat, 15, 0, 0, 4);
        chk("R10 last byte", int'(capmem[3]), 'h44);
        idle_gap();

        // R12: a second start while busy changes nothing
        setup(1, 0, 0, 0, 16);
        run("R12", 0, 1, lat); expect_res("R12", lat, 10, 2, 5, 0);
        repeat (25) @(negedge clk);
        chk("R12 no second result", int'(res_valid), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule